// File: doc/BRIEF.md
# Interrupt Request Priority Controller

This block keeps the interrupt state of one processor core across 256 vectors. It holds three bit arrays: pending requests, vectors in service, and a trigger-mode flag per vector. From these arrays, a task priority register and the highest vector in service, it works out a processor priority. It then decides whether the highest pending request may interrupt the core, and drives a level interrupt line when it may.

The core answers the line with a one-cycle acknowledge strobe. On the next cycle the block returns the granted vector and moves it from pending to in service. If no request can be granted, it returns a programmable spurious vector and changes nothing. An end-of-interrupt strobe retires the highest vector in service. If that vector was level-triggered, the block sends a one-cycle broadcast carrying the vector to the sources upstream. Any 32-bit word of each array can be read back through a word-select input.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Vector v is held at bit v mod 32 of word v div 32 in each of the three arrays, and rd_word selects the word shown on irr_word, isr_word and tmr_word.
- R2: When several vectors are pending or in service, the highest-numbered one is the one the block treats as the highest.
- R3: A req_valid strobe sets the pending bit of req_vector. It also sets that vector's trigger bit when req_level is 1 and clears it when req_level is 0. The arrays change one clock after the strobe.
- R4: The highest pending request is blocked when ppr_out is nonzero and the upper nibble of the request is less than or equal to the upper nibble of ppr_out.
- R5: An ack strobe with an unblocked pending request, while the block is enabled, clears that request's pending bit and sets its in-service bit. One cycle later it raises ack_valid with ack_spurious = 0 and ack_vector = the vector.
- R6: An ack strobe with no grantable request (array empty, request blocked, or block disabled) leaves all arrays unchanged. One cycle later it raises ack_valid with ack_spurious = 1 and ack_vector = bits 7:0 of the spurious register.
- R7: An eoi strobe clears the highest in-service bit. If that vector's trigger bit is set, eoi_bcast pulses for exactly one cycle, one cycle after the strobe, with eoi_bcast_vector = that vector. Otherwise eoi_bcast stays low.
- R8: While bit 8 of the spurious register (the enable) is 0, irq_out is 0.
- R9: irq_out is registered. It reflects the arrays, the task priority and the spurious register as they stood one clock earlier.
- R10: A spurious register write keeps only bits 8:0 of svr_wdata. A 1 written at bit 12 therefore has no effect, and level-triggered EOIs still broadcast.
- R11: ppr_out equals the task priority when no vector is in service or when the task priority's upper nibble is at least the highest in-service vector's upper nibble. Otherwise it equals that vector with its low nibble cleared.
- R12: While rst_n is low at a clock edge, all three arrays, the task priority, the spurious register and all outputs are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New interrupt request strobe |
| req_vector | input | 8 | Vector of the new request |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| svr_we | input | 1 | Spurious register write strobe |
| svr_wdata | input | 32 | Spurious register write data (bits 8:0 kept) |
| ack | input | 1 | Core acknowledge strobe |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Granted or spurious vector |
| ack_spurious | output | 1 | Response is the spurious vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_bcast | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bcast_vector | output | 8 | Vector carried by the broadcast |
| irq_out | output | 1 | Interrupt line to the core |
| ppr_out | output | 8 | Current processor priority |
| rd_word | input | 3 | Word select for readback |
| irr_word | output | 32 | Selected word of the pending array |
| isr_word | output | 32 | Selected word of the in-service array |
| tmr_word | output | 32 | Selected word of the trigger-mode array |

## Verification
The bench builds the block with its defaults of 256 vectors in 32-bit words. This puts vectors 0, 31, 32 and 255 within reach, so the first and last bits of a word and the first and last words can be checked directly. With 8-bit vectors, every priority class from 0 to 15 can be tested. The bench uses this to exercise blocking at equal classes, task priority values just above and just below a request's class, and nested in-service vectors of different classes.

// File: rtl/irqp_pkg.sv
// Shared constants for the interrupt priority controller.
// Assumes vectors are at least CLASS_W bits wide.
package irqp_pkg;
    localparam int CLASS_W  = 4;   // width of a priority class (upper vector bits)
    localparam int SVR_W    = 9;   // spurious register bits kept
    localparam int SVR_EN   = 8;   // software-enable bit position
endpackage

// File: rtl/irqp_top_finder.sv
// Finds the highest-numbered set bit of a bit array.
// Assumes N <= 2**IW. Reports found = 0 for an empty array.
module irqp_top_finder #(
    parameter int N  = 256,
    parameter int IW = 8
) (
    input  logic [N-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan upward so that the last set bit seen (the highest) wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqp_gate.sv
// Computes the processor priority and decides whether the top request is deliverable.
// Assumes the class of a vector is its upper CLASS_W bits.
module irqp_gate
    import irqp_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic [VW-1:0] tpr,
    input  logic          isr_found,
    input  logic [VW-1:0] isr_top,
    input  logic          irr_found,
    input  logic [VW-1:0] irr_top,
    output logic [VW-1:0] ppr,
    output logic          deliverable
);
    logic [CLASS_W-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

    assign tpr_cls = tpr[VW-1 -: CLASS_W];
    assign isr_cls = isr_top[VW-1 -: CLASS_W];
    assign irr_cls = irr_top[VW-1 -: CLASS_W];

    // Processor priority: task priority, or class of the highest in-service vector.
    always_comb begin
        if (!isr_found || tpr_cls >= isr_cls) ppr = tpr;
        else                                  ppr = {isr_cls, {(VW-CLASS_W){1'b0}}};
    end

    assign ppr_cls = ppr[VW-1 -: CLASS_W];

    // Gate the top request against the processor priority class.
    assign deliverable = irr_found && !((ppr != '0) && (irr_cls <= ppr_cls));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Pending / in-service / trigger-mode tracking with priority gating, acknowledge and EOI.
// Assumes at most one of req, ack, eoi touches the same vector in one cycle;
// when it happens, setting a bit wins over clearing it.
module irq_prio_ctrl
    import irqp_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [$clog2(NUM_VEC)-1:0]      req_vector,
    input  logic                            req_level,
    input  logic                            tpr_we,
    input  logic [$clog2(NUM_VEC)-1:0]      tpr_wdata,
    input  logic                            svr_we,
    input  logic [31:0]                     svr_wdata,
    input  logic                            ack,
    output logic                            ack_valid,
    output logic [$clog2(NUM_VEC)-1:0]      ack_vector,
    output logic                            ack_spurious,
    input  logic                            eoi,
    output logic                            eoi_bcast,
    output logic [$clog2(NUM_VEC)-1:0]      eoi_bcast_vector,
    output logic                            irq_out,
    output logic [$clog2(NUM_VEC)-1:0]      ppr_out,
    input  logic [$clog2(NUM_VEC/WORD_W)-1:0] rd_word,
    output logic [WORD_W-1:0]               irr_word,
    output logic [WORD_W-1:0]               isr_word,
    output logic [WORD_W-1:0]               tmr_word
);
    localparam int VW        = $clog2(NUM_VEC);
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};

    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [VW-1:0]      tpr_q;
    logic [SVR_W-1:0]   svr_q;

    logic          irr_found, isr_found, deliverable, enabled, take;
    logic [VW-1:0] irr_top, isr_top, ppr;
    logic [NUM_VEC-1:0] irr_set, irr_clr, isr_set, isr_clr, req_hot;

    irqp_top_finder #(.N(NUM_VEC), .IW(VW)) u_irr_find (
        .bits(irr_q), .found(irr_found), .idx(irr_top));
    irqp_top_finder #(.N(NUM_VEC), .IW(VW)) u_isr_find (
        .bits(isr_q), .found(isr_found), .idx(isr_top));
    irqp_gate #(.VW(VW)) u_gate (
        .tpr(tpr_q), .isr_found(isr_found), .isr_top(isr_top),
        .irr_found(irr_found), .irr_top(irr_top),
        .ppr(ppr), .deliverable(deliverable));

    assign enabled = svr_q[SVR_EN];
    assign take    = ack && enabled && deliverable;
    assign ppr_out = ppr;

    // Build the one-hot set and clear masks for this cycle.
    always_comb begin
        req_hot = ONE << req_vector;
        irr_set = req_valid ? req_hot : '0;
        irr_clr = take ? (ONE << irr_top) : '0;
        isr_set = irr_clr;
        isr_clr = (eoi && isr_found) ? (ONE << isr_top) : '0;
    end

    // Update the three arrays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= (irr_q & ~irr_clr) | irr_set;
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (req_valid) tmr_q <= req_level ? (tmr_q | req_hot) : (tmr_q & ~req_hot);
        end
    end

    // Hold the task priority and the kept spurious register bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
            svr_q <= '0;
        end else begin
            if (tpr_we) tpr_q <= tpr_wdata;
            if (svr_we) svr_q <= svr_wdata[SVR_W-1:0];
        end
    end

    // Register the acknowledge response, the EOI broadcast and the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid        <= 1'b0;
            ack_vector       <= '0;
            ack_spurious     <= 1'b0;
            eoi_bcast        <= 1'b0;
            eoi_bcast_vector <= '0;
            irq_out          <= 1'b0;
        end else begin
            ack_valid        <= ack;
            ack_spurious     <= ack && !take;
            if (ack) ack_vector <= take ? irr_top : svr_q[VW-1:0];
            eoi_bcast        <= eoi && isr_found && tmr_q[isr_top];
            if (eoi) eoi_bcast_vector <= isr_top;
            irq_out          <= enabled && deliverable;
        end
    end

    // Split each array into readable words.
    logic [WORD_W-1:0] irr_w [NUM_WORDS];
    logic [WORD_W-1:0] isr_w [NUM_WORDS];
    logic [WORD_W-1:0] tmr_w [NUM_WORDS];
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_words
        assign irr_w[g] = irr_q[g*WORD_W +: WORD_W];
        assign isr_w[g] = isr_q[g*WORD_W +: WORD_W];
        assign tmr_w[g] = tmr_q[g*WORD_W +: WORD_W];
    end

    assign irr_word = irr_w[rd_word];
    assign isr_word = isr_w[rd_word];
    assign tmr_word = tmr_w[rd_word];
endmodule

// File: rtl/irqp_checker.sv
// Temporal checks on the interrupt priority controller, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module irqp_checker #(
    parameter int NUM_VEC = 256,
    parameter int VW      = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VW-1:0]      req_vector,
    input logic               ack,
    input logic               ack_valid,
    input logic               ack_spurious,
    input logic [VW-1:0]      ack_vector,
    input logic               eoi,
    input logic               eoi_bcast,
    input logic               irq_out,
    input logic [8:0]         svr_q,
    input logic [NUM_VEC-1:0] irr_q,
    input logic [NUM_VEC-1:0] isr_q
);
    p_req_sets_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> irr_q[$past(req_vector)]);

    p_ack_response_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ack));

    p_grant_in_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_spurious) |-> isr_q[ack_vector]);

    p_spurious_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_spurious) |-> (ack_vector == $past(svr_q[7:0])));

    p_bcast_after_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(eoi));

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !svr_q[8] |=> !irq_out);
endmodule

bind irq_prio_ctrl irqp_checker #(.NUM_VEC(NUM_VEC), .VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .ack(ack), .ack_valid(ack_valid), .ack_spurious(ack_spurious),
    .ack_vector(ack_vector), .eoi(eoi), .eoi_bcast(eoi_bcast),
    .irq_out(irq_out), .svr_q(svr_q), .irr_q(irr_q), .isr_q(isr_q));

// File: tb/irq_prio_ctrl_test.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_level = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        tpr_we = 1'b0, svr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic [31:0] svr_wdata = '0;
    logic        ack = 1'b0, eoi = 1'b0;
    logic [2:0]  rd_word = '0;
    logic        ack_valid, ack_spurious, eoi_bcast, irq_out;
    logic [7:0]  ack_vector, eoi_bcast_vector, ppr_out;
    logic [31:0] irr_word, isr_word, tmr_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_level(req_level), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .svr_we(svr_we), .svr_wdata(svr_wdata), .ack(ack), .ack_valid(ack_valid),
        .ack_vector(ack_vector), .ack_spurious(ack_spurious), .eoi(eoi),
        .eoi_bcast(eoi_bcast), .eoi_bcast_vector(eoi_bcast_vector),
        .irq_out(irq_out), .ppr_out(ppr_out), .rd_word(rd_word),
        .irr_word(irr_word), .isr_word(isr_word), .tmr_word(tmr_word));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic send_req(input logic [7:0] v, input logic lvl);
        req_valid = 1'b1; req_vector = v; req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr_svr(input logic [31:0] d);
        svr_we = 1'b1; svr_wdata = d;
        @(negedge clk);
        svr_we = 1'b0;
    endtask

    task automatic wr_tpr(input logic [7:0] d);
        tpr_we = 1'b1; tpr_wdata = d;
        @(negedge clk);
        tpr_we = 1'b0;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic sp);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        v = ack_vector; sp = ack_spurious;
        checks++;
        if (ack_valid !== 1'b1) begin
            fails++;
            $display("FAIL R5 ack_valid actual=%b expected=1", ack_valid);
        end
    endtask

    task automatic do_eoi(output logic b, output logic [7:0] v);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
        b = eoi_bcast; v = eoi_bcast_vector;
    endtask

    task automatic rd(input int w, output logic [31:0] i_r, output logic [31:0] i_s,
                      output logic [31:0] i_t);
        rd_word = 3'(w);
        #1;
        i_r = irr_word; i_s = isr_word; i_t = tmr_word;
    endtask

    task automatic t_reset();
        logic [31:0] a, b, c;
        do_reset();
        chk("R12 irq_out", 32'(irq_out), 0);
        chk("R12 ppr_out", 32'(ppr_out), 0);
        chk("R12 ack_valid", 32'(ack_valid), 0);
        for (int w = 0; w < 8; w++) begin
            rd(w, a, b, c);
            chk("R12 arrays clear", a | b | c, 0);
        end
    endtask

    task automatic t_request();
        logic [31:0] a, b, c;
        do_reset();
        wr_svr(32'h1FF);
        send_req(8'h45, 1'b0);
        chk("R9 irq not yet", 32'(irq_out), 0);
        settle();
        chk("R9 irq one clock later", 32'(irq_out), 1);
        rd(2, a, b, c);
        chk("R1 R3 pending bit", a, 32'h20);
        chk("R3 edge trigger bit", c, 0);
        send_req(8'h47, 1'b1);
        rd(2, a, b, c);
        chk("R3 level trigger bit", c, 32'h80);
        send_req(8'h47, 1'b0);
        rd(2, a, b, c);
        chk("R3 trigger cleared", c, 0);
        chk("R3 pending word", a, 32'hA0);
    endtask

    task automatic t_ack_block();
        logic [31:0] a, b, c;
        logic [7:0]  v;
        logic        sp, bc;
        do_reset();
        wr_svr(32'h1FF);
        send_req(8'h45, 1'b0);
        send_req(8'h47, 1'b0);
        do_ack(v, sp);
        chk("R2 R5 grant highest", 32'(v), 32'h47);
        chk("R5 not spurious", 32'(sp), 0);
        rd(2, a, b, c);
        chk("R5 pending cleared", a, 32'h20);
        chk("R5 in service set", b, 32'h80);
        chk("R11 ppr from in-service", 32'(ppr_out), 32'h40);
        settle();
        chk("R4 equal class blocks irq", 32'(irq_out), 0);
        do_ack(v, sp);
        chk("R6 blocked spurious flag", 32'(sp), 1);
        chk("R6 blocked spurious vector", 32'(v), 32'hFF);
        rd(2, a, b, c);
        chk("R6 pending unchanged", a, 32'h20);
        chk("R6 in service unchanged", b, 32'h80);
        do_eoi(bc, v);
        chk("R7 edge vector no broadcast", 32'(bc), 0);
        rd(2, a, b, c);
        chk("R7 in service cleared", b, 0);
        settle();
        chk("R4 unblocked after eoi", 32'(irq_out), 1);
        do_ack(v, sp);
        chk("R5 grant after eoi", 32'(v), 32'h45);
    endtask

    task automatic t_eoi_level();
        logic [31:0] a, b, c;
        logic [7:0]  v;
        logic        sp, bc;
        do_reset();
        wr_svr(32'h1FF);
        send_req(8'h30, 1'b0);
        do_ack(v, sp);
        chk("R5 grant low", 32'(v), 32'h30);
        send_req(8'h90, 1'b1);
        do_ack(v, sp);
        chk("R5 nested grant", 32'(v), 32'h90);
        chk("R11 ppr nested", 32'(ppr_out), 32'h90);
        do_eoi(bc, v);
        chk("R7 level broadcast", 32'(bc), 1);
        chk("R7 broadcast vector", 32'(v), 32'h90);
        settle();
        chk("R7 broadcast one cycle", 32'(eoi_bcast), 0);
        rd(1, a, b, c);
        chk("R2 R7 lower still in service", b, 32'h0001_0000);
        do_eoi(bc, v);
        chk("R7 edge no broadcast", 32'(bc), 0);
        rd(1, a, b, c);
        chk("R7 all retired", b, 0);
    endtask

    task automatic t_tpr();
        logic [7:0] v;
        logic       sp;
        do_reset();
        wr_svr(32'h1FF);
        send_req(8'h45, 1'b0);
        wr_tpr(8'h50);
        settle();
        chk("R4 higher tpr blocks", 32'(irq_out), 0);
        chk("R11 ppr equals tpr", 32'(ppr_out), 32'h50);
        wr_tpr(8'h40);
        settle();
        chk("R4 equal class tpr blocks", 32'(irq_out), 0);
        wr_tpr(8'h3F);
        settle();
        chk("R4 lower class tpr passes", 32'(irq_out), 1);
        chk("R11 ppr low nibble kept", 32'(ppr_out), 32'h3F);
        do_ack(v, sp);
        chk("R5 grant under tpr", 32'(v), 32'h45);
        chk("R11 ppr from in-service over tpr", 32'(ppr_out), 32'h40);
    endtask

    task automatic t_bounds();
        logic [31:0] a, b, c;
        logic [7:0]  v;
        logic        sp, bc;
        do_reset();
        wr_svr(32'h1FF);
        send_req(8'd0, 1'b0);
        send_req(8'd255, 1'b0);
        send_req(8'd31, 1'b0);
        send_req(8'd32, 1'b0);
        rd(0, a, b, c);
        chk("R1 word0 edges", a, 32'h8000_0001);
        rd(1, a, b, c);
        chk("R1 word1 first bit", a, 32'h1);
        rd(7, a, b, c);
        chk("R1 word7 last bit", a, 32'h8000_0000);
        do_ack(v, sp); chk("R2 top vector 255", 32'(v), 255); do_eoi(bc, v);
        do_ack(v, sp); chk("R2 next vector 32", 32'(v), 32);  do_eoi(bc, v);
        do_ack(v, sp); chk("R2 next vector 31", 32'(v), 31);  do_eoi(bc, v);
        do_ack(v, sp); chk("R4 vector 0 with ppr 0", 32'(v), 0);
        chk("R5 vector 0 not spurious", 32'(sp), 0);
    endtask

    task automatic t_disable_svr();
        logic [31:0] a, b, c;
        logic [7:0]  v;
        logic        sp, bc;
        do_reset();
        wr_svr(32'h1FF);
        send_req(8'h60, 1'b1);
        settle();
        chk("R8 enabled irq", 32'(irq_out), 1);
        wr_svr(32'h0EE);
        settle();
        chk("R8 disabled irq low", 32'(irq_out), 0);
        do_ack(v, sp);
        chk("R6 disabled spurious", 32'(v), 32'hEE);
        chk("R6 disabled flag", 32'(sp), 1);
        rd(3, a, b, c);
        chk("R6 disabled pending kept", a, 32'h1);
        wr_svr(32'hFFFF_F1AB);
        settle();
        chk("R10 enable bit kept", 32'(irq_out), 1);
        do_ack(v, sp);
        chk("R10 grant after rewrite", 32'(v), 32'h60);
        send_req(8'h20, 1'b0);
        do_ack(v, sp);
        chk("R10 spurious low byte", 32'(v), 32'hAB);
        do_eoi(bc, v);
        chk("R10 bit 12 dropped, broadcast", 32'(bc), 1);
        chk("R7 broadcast vector", 32'(v), 32'h60);
    endtask

    initial begin
        t_reset();
        t_request();
        t_ack_block();
        t_eoi_level();
        t_tpr();
        t_bounds();
        t_disable_svr();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (R1..R12 run) actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule